// File: doc/BRIEF.md
# Connection Memory Block Initializer

This block owns the connection memory of a time slot switch and can fill every entry with one control pattern in a single hardware sweep. Without it, the host would have to write each entry by itself. The host writes a control word that holds a 4-bit pattern, an enable bit and a start bit.

When start is set while enable is high, the block walks through every address. Each entry receives the pattern in its top nibble and zeros in its lower twelve bits. At the end of the walk the block clears the start bit.

The serial datapath keeps read priority on the single memory port. The sweep writes one entry in each cycle that the datapath leaves free. Host accesses to the memory wait until the sweep is over. A full sweep takes DEPTH free cycles, which keeps it well inside two frames even while the datapath is busy.

Control word layout:

| Bits | Field |
|---|---|
| 0 | enable |
| 1 | start |
| 8:5 | pattern |
| others | read back as 0 |

Top module: `cm_block_init`

## Requirements
- R1: After reset the control word reads back as 0 and hst_ack_o is low.
- R2: A control write with start = 1 and enable (bit 0) = 0 is not honoured. The start bit reads back as 0 and no memory entry changes.
- R3: A completed sweep leaves every entry with bits 15:12 equal to the pattern from control bits 8:5.
- R4: A completed sweep leaves bits 11:0 of every entry at zero.
- R5: With no datapath reads, the start bit reads 1 for exactly DEPTH cycles after the control write and is then cleared by the hardware. The enable bit stays set.
- R6: A host request made during a sweep is not acknowledged while start is set. It is granted in the first cycle after the sweep, so a host write lands after the sweep's write to the same address.
- R7: Each cycle with dp_rd_en_i high during a sweep delays completion by exactly one cycle. The read data appears on dp_rdata_o in the following cycle.
- R8: A control write that clears enable during a sweep aborts it. Start reads 0 at once, and entries not yet reached keep their old contents.
- R9: When idle, a host access is acknowledged one cycle after the request. Read data is valid while hst_ack_o is high, and the ack lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ctrl_we_i | input | 1 | Control word write strobe |
| ctrl_wdata_i | input | 16 | Control word: bit 0 enable, bit 1 start, bits 8:5 pattern |
| ctrl_rdata_o | output | 16 | Control word readback |
| hst_req_i | input | 1 | Host memory request, held until acknowledged |
| hst_we_i | input | 1 | Host write (1) or read (0) |
| hst_addr_i | input | clog2(DEPTH) | Host memory address |
| hst_wdata_i | input | 16 | Host write data |
| hst_ack_o | output | 1 | One-cycle host acknowledge |
| hst_rdata_o | output | 16 | Host read data, valid with hst_ack_o |
| dp_rd_en_i | input | 1 | Datapath read request, highest priority |
| dp_addr_i | input | clog2(DEPTH) | Datapath read address |
| dp_rdata_o | output | 16 | Datapath read data, one cycle after the request |

## Verification
The sweep write and a datapath read can both want the memory port in the same cycle. The bench provokes this by raising dp_rd_en_i during the first cycles of a sweep, with the read aimed at the last address. The collision is judged two ways. The start bit must stay set for exactly DEPTH plus the number of stalled cycles. The first read must return the previous sweep's pattern, since that address has not been rewritten yet. A second collision is also provoked: a host write held pending across a whole sweep, which must be acknowledged only in the cycle after completion.

// File: rtl/cmi_pkg.sv
package cmi_pkg;
  localparam int CM_W     = 16;
  localparam int CTRL_W   = 16;
  localparam int PAT_W    = 4;
  localparam int PAT_LSB  = 5;
  localparam int EN_BIT   = 0;
  localparam int GO_BIT   = 1;

  typedef enum logic [1:0] {
    GNT_NONE  = 2'd0,
    GNT_DP    = 2'd1,
    GNT_SWEEP = 2'd2,
    GNT_HOST  = 2'd3
  } gnt_e;
endpackage

// File: rtl/cmi_mem.sv
module cmi_mem #(
  parameter int DEPTH = 256,
  parameter int W     = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          en_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [W-1:0]  wdata_i,
  output logic [W-1:0]  rdata_o
);
  logic [W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (en_i) begin
      if (we_i) mem_q[addr_i] <= wdata_i;
      else      rdata_o       <= mem_q[addr_i];
    end
  end
endmodule

// File: rtl/cmi_ctrl.sv
module cmi_ctrl
  import cmi_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [CTRL_W-1:0] wdata_i,
  input  logic              done_i,
  output logic              en_o,
  output logic              go_o,
  output logic [PAT_W-1:0]  pat_o,
  output logic [CTRL_W-1:0] rdata_o
);
  logic unused_ctrl_bits;
  assign unused_ctrl_bits = ^{wdata_i[CTRL_W-1:PAT_LSB+PAT_W], wdata_i[PAT_LSB-1:GO_BIT+1]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o  <= 1'b0;
      go_o  <= 1'b0;
      pat_o <= '0;
    end else if (we_i) begin
      en_o  <= wdata_i[EN_BIT];
      // start only sticks when enable is set; clearing enable aborts
      go_o  <= wdata_i[GO_BIT] & wdata_i[EN_BIT];
      pat_o <= wdata_i[PAT_LSB +: PAT_W];
    end else if (done_i) begin
      go_o  <= 1'b0;
    end
  end

  always_comb begin
    rdata_o                   = '0;
    rdata_o[EN_BIT]           = en_o;
    rdata_o[GO_BIT]           = go_o;
    rdata_o[PAT_LSB +: PAT_W] = pat_o;
  end
endmodule

// File: rtl/cmi_sweep.sv
module cmi_sweep
  import cmi_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH),
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             go_i,
  input  logic             slot_free_i,
  input  logic [PAT_W-1:0] pat_i,
  output logic             we_o,
  output logic [AW-1:0]    addr_o,
  output logic [CM_W-1:0]  wdata_o,
  output logic             done_o
);
  logic [AW-1:0] cnt_q;

  assign we_o    = go_i & slot_free_i;
  assign addr_o  = cnt_q;
  assign wdata_o = {pat_i, {(CM_W-PAT_W){1'b0}}};
  assign done_o  = we_o && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cnt_q <= '0;
    else if (!go_i) cnt_q <= '0;
    else if (we_o)  cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/cmi_arb.sv
module cmi_arb
  import cmi_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            dp_rd_en_i,
  input  logic [AW-1:0]   dp_addr_i,
  input  logic            go_i,
  input  logic            sw_we_i,
  input  logic [AW-1:0]   sw_addr_i,
  input  logic [CM_W-1:0] sw_wdata_i,
  input  logic            hst_req_i,
  input  logic            hst_we_i,
  input  logic [AW-1:0]   hst_addr_i,
  input  logic [CM_W-1:0] hst_wdata_i,
  output logic            slot_free_o,
  output logic            hst_ack_o,
  output logic            mem_en_o,
  output logic            mem_we_o,
  output logic [AW-1:0]   mem_addr_o,
  output logic [CM_W-1:0] mem_wdata_o
);
  gnt_e gnt;

  assign slot_free_o = ~dp_rd_en_i;

  always_comb begin
    if (dp_rd_en_i)                          gnt = GNT_DP;
    else if (sw_we_i)                        gnt = GNT_SWEEP;
    else if (hst_req_i && !go_i && !hst_ack_o) gnt = GNT_HOST;
    else                                     gnt = GNT_NONE;
  end

  always_comb begin
    mem_en_o    = 1'b1;
    mem_we_o    = 1'b0;
    mem_addr_o  = dp_addr_i;
    mem_wdata_o = sw_wdata_i;
    unique case (gnt)
      GNT_DP:    ;
      GNT_SWEEP: begin
        mem_we_o   = 1'b1;
        mem_addr_o = sw_addr_i;
      end
      GNT_HOST: begin
        mem_we_o    = hst_we_i;
        mem_addr_o  = hst_addr_i;
        mem_wdata_o = hst_wdata_i;
      end
      default:   mem_en_o = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hst_ack_o <= 1'b0;
    else         hst_ack_o <= (gnt == GNT_HOST);
  end
endmodule

// File: rtl/cm_block_init.sv
module cm_block_init
  import cmi_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_we_i,
  input  logic [CTRL_W-1:0] ctrl_wdata_i,
  output logic [CTRL_W-1:0] ctrl_rdata_o,
  input  logic              hst_req_i,
  input  logic              hst_we_i,
  input  logic [AW-1:0]     hst_addr_i,
  input  logic [CM_W-1:0]   hst_wdata_i,
  output logic              hst_ack_o,
  output logic [CM_W-1:0]   hst_rdata_o,
  input  logic              dp_rd_en_i,
  input  logic [AW-1:0]     dp_addr_i,
  output logic [CM_W-1:0]   dp_rdata_o
);
  logic             en, go, done;
  logic [PAT_W-1:0] pat;
  logic             slot_free;
  logic             sweep_we;
  logic [AW-1:0]    sweep_addr;
  logic [CM_W-1:0]  sweep_wdata;
  logic             mem_en, mem_we;
  logic [AW-1:0]    mem_addr;
  logic [CM_W-1:0]  mem_wdata, mem_rdata;
  logic             unused_en;

  assign unused_en = en;

  cmi_ctrl u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (ctrl_we_i),
    .wdata_i (ctrl_wdata_i),
    .done_i  (done),
    .en_o    (en),
    .go_o    (go),
    .pat_o   (pat),
    .rdata_o (ctrl_rdata_o)
  );

  cmi_sweep #(.DEPTH(DEPTH)) u_sweep (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .go_i        (go),
    .slot_free_i (slot_free),
    .pat_i       (pat),
    .we_o        (sweep_we),
    .addr_o      (sweep_addr),
    .wdata_o     (sweep_wdata),
    .done_o      (done)
  );

  cmi_arb #(.DEPTH(DEPTH)) u_arb (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .dp_rd_en_i  (dp_rd_en_i),
    .dp_addr_i   (dp_addr_i),
    .go_i        (go),
    .sw_we_i     (sweep_we),
    .sw_addr_i   (sweep_addr),
    .sw_wdata_i  (sweep_wdata),
    .hst_req_i   (hst_req_i),
    .hst_we_i    (hst_we_i),
    .hst_addr_i  (hst_addr_i),
    .hst_wdata_i (hst_wdata_i),
    .slot_free_o (slot_free),
    .hst_ack_o   (hst_ack_o),
    .mem_en_o    (mem_en),
    .mem_we_o    (mem_we),
    .mem_addr_o  (mem_addr),
    .mem_wdata_o (mem_wdata)
  );

  cmi_mem #(.DEPTH(DEPTH), .W(CM_W)) u_mem (
    .clk_i   (clk_i),
    .en_i    (mem_en),
    .we_i    (mem_we),
    .addr_i  (mem_addr),
    .wdata_i (mem_wdata),
    .rdata_o (mem_rdata)
  );

  assign hst_rdata_o = mem_rdata;
  assign dp_rdata_o  = mem_rdata;
endmodule

// File: rtl/cmi_chk.sv
module cmi_chk #(
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH),
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [15:0]   ctrl_rdata,
  input logic          ctrl_we,
  input logic          hst_ack,
  input logic          dp_rd_en,
  input logic          go,
  input logic          sweep_we,
  input logic [AW-1:0] sweep_addr,
  input logic [15:0]   sweep_wdata
);
  AST_START_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_rdata[1] |-> ctrl_rdata[0]); // R2

  AST_SWEEP_PATTERN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sweep_we |-> (sweep_wdata[15:12] == ctrl_rdata[8:5] && sweep_wdata[11:0] == 12'h000)); // R3 R4

  AST_SELF_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(go) && !$past(ctrl_we)) |-> $past(sweep_we && sweep_addr == LAST)); // R5

  AST_HOST_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go |=> !hst_ack); // R6

  AST_DP_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dp_rd_en |-> !sweep_we); // R7

  AST_ACK_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hst_ack |=> !hst_ack); // R9
endmodule

bind cm_block_init cmi_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ctrl_rdata  (ctrl_rdata_o),
  .ctrl_we     (ctrl_we_i),
  .hst_ack     (hst_ack_o),
  .dp_rd_en    (dp_rd_en_i),
  .go          (go),
  .sweep_we    (sweep_we),
  .sweep_addr  (sweep_addr),
  .sweep_wdata (sweep_wdata)
);

// File: tb/sim_cm_block_init.sv
module sim_cm_block_init;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 64;
  localparam int AW         = $clog2(DEPTH);
  localparam int NVEC       = 4;
  // vector: {pattern[7:4], datapath stall cycles[3:0]}
  localparam logic [7:0] VEC [NVEC] = '{8'hA0, 8'h53, 8'hF1, 8'h37};

  logic          clk = 1'b0;
  logic          rst_n;
  logic          ctrl_we;
  logic [15:0]   ctrl_wdata;
  logic [15:0]   ctrl_rdata;
  logic          hst_req, hst_we, hst_ack;
  logic [AW-1:0] hst_addr;
  logic [15:0]   hst_wdata, hst_rdata;
  logic          dp_rd_en;
  logic [AW-1:0] dp_addr;
  logic [15:0]   dp_rdata;

  int  checks = 0;
  int  errors = 0;
  bit  finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cm_block_init #(.DEPTH(DEPTH)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .ctrl_we_i(ctrl_we), .ctrl_wdata_i(ctrl_wdata), .ctrl_rdata_o(ctrl_rdata),
    .hst_req_i(hst_req), .hst_we_i(hst_we), .hst_addr_i(hst_addr),
    .hst_wdata_i(hst_wdata), .hst_ack_o(hst_ack), .hst_rdata_o(hst_rdata),
    .dp_rd_en_i(dp_rd_en), .dp_addr_i(dp_addr), .dp_rdata_o(dp_rdata)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] cw(input logic [3:0] pat, input bit en, input bit go);
    return {7'b0, pat, 3'b0, go, en};
  endfunction

  task automatic ctrl_wr(input logic [15:0] v);
    @(negedge clk);
    ctrl_we = 1'b1; ctrl_wdata = v;
    @(negedge clk);
    ctrl_we = 1'b0;
  endtask

  task automatic hst_acc(input bit we, input logic [AW-1:0] a, input logic [15:0] d,
                         output logic [15:0] rd, output int lat);
    @(negedge clk);
    hst_req = 1'b1; hst_we = we; hst_addr = a; hst_wdata = d;
    lat = 0;
    do begin @(negedge clk); lat++; end while (!hst_ack);
    rd = hst_rdata;
    hst_req = 1'b0; hst_we = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    checks++; errors++;
    $display("FAIL watchdog act=0 exp=1");
    finish_run();
  end

  initial begin
    logic [15:0] rd;
    logic [3:0]  prev;
    int lat, cnt, bad_hi, bad_lo;
    rst_n = 1'b0; ctrl_we = 0; ctrl_wdata = 0; hst_req = 0; hst_we = 0;
    hst_addr = 0; hst_wdata = 0; dp_rd_en = 0; dp_addr = 0;
    prev = 4'h0;
    repeat (3) @(negedge clk);
    chk(ctrl_rdata == 16'h0, "R1 ctrl reset", ctrl_rdata, 0);
    chk(hst_ack == 1'b0, "R1 ack reset", hst_ack, 0);
    rst_n = 1'b1;

    // idle host write/read
    hst_acc(1'b1, 6'd3, 16'h1234, rd, lat);
    chk(lat == 1, "R9 write latency", lat, 1);
    hst_acc(1'b0, 6'd3, 16'h0, rd, lat);
    chk(lat == 1, "R9 read latency", lat, 1);
    chk(rd == 16'h1234, "R9 read data", rd, 16'h1234);
    @(negedge clk);
    chk(hst_ack == 1'b0, "R9 ack one cycle", hst_ack, 0);

    // start without enable
    ctrl_wr(cw(4'h7, 1'b0, 1'b1));
    chk(ctrl_rdata[1] == 1'b0, "R2 start ignored", ctrl_rdata, 0);
    repeat (DEPTH + 2) @(negedge clk);
    hst_acc(1'b0, 6'd3, 16'h0, rd, lat);
    chk(rd == 16'h1234, "R2 memory untouched", rd, 16'h1234);

    // vector table: sweeps with datapath stalls
    for (int v = 0; v < NVEC; v++) begin
      logic [3:0] pat;
      int nr;
      pat = VEC[v][7:4];
      nr  = int'(VEC[v][3:0]);
      ctrl_wr(cw(pat, 1'b1, 1'b1));
      chk(ctrl_rdata[1] == 1'b1, "R5 start set", ctrl_rdata, 16'h2);
      cnt = 0;
      while (ctrl_rdata[1]) begin
        dp_rd_en = (cnt < nr);
        dp_addr  = AW'(DEPTH - 1);
        @(negedge clk);
        if (cnt == 0 && nr > 0)
          chk(dp_rdata == {prev, 12'h000}, "R7 dp read data", dp_rdata, {prev, 12'h000});
        cnt++;
        if (cnt > 4 * DEPTH) break;
      end
      dp_rd_en = 1'b0;
      chk(cnt == DEPTH + nr, (nr > 0) ? "R7 stall adds cycles" : "R5 sweep length", cnt, DEPTH + nr);
      chk(ctrl_rdata[0] == 1'b1, "R5 enable kept", ctrl_rdata, 1);
      bad_hi = 0; bad_lo = 0;
      for (int a = 0; a < DEPTH; a++) begin
        hst_acc(1'b0, AW'(a), 16'h0, rd, lat);
        if (rd[15:12] !== pat) bad_hi++;
        if (rd[11:0] !== 12'h000) bad_lo++;
      end
      chk(bad_hi == 0, "R3 pattern nibble", bad_hi, 0);
      chk(bad_lo == 0, "R4 low bits zero", bad_lo, 0);
      prev = pat;
    end

    // host write pending across a sweep
    ctrl_wr(cw(4'h9, 1'b1, 1'b1));
    hst_req = 1'b1; hst_we = 1'b1; hst_addr = 6'd5; hst_wdata = 16'h0ABC;
    lat = 0;
    do begin @(negedge clk); lat++; end while (!hst_ack && lat < 4 * DEPTH);
    hst_req = 1'b0; hst_we = 1'b0;
    chk(lat == DEPTH + 1, "R6 host held during sweep", lat, DEPTH + 1);
    hst_acc(1'b0, 6'd5, 16'h0, rd, lat);
    chk(rd == 16'h0ABC, "R6 host write after sweep", rd, 16'h0ABC);
    hst_acc(1'b0, 6'd6, 16'h0, rd, lat);
    chk(rd == 16'h9000, "R6 neighbour swept", rd, 16'h9000);

    // abort by clearing enable
    ctrl_wr(cw(4'h2, 1'b1, 1'b1));
    repeat (5) @(negedge clk);
    ctrl_wr(cw(4'h2, 1'b0, 1'b1));
    chk(ctrl_rdata[1] == 1'b0, "R8 start cleared on abort", ctrl_rdata, 0);
    repeat (DEPTH) @(negedge clk);
    hst_acc(1'b0, 6'd0, 16'h0, rd, lat);
    chk(rd == 16'h2000, "R8 early entry written", rd, 16'h2000);
    hst_acc(1'b0, AW'(DEPTH - 1), 16'h0, rd, lat);
    chk(rd == 16'h9000, "R8 late entry kept", rd, 16'h9000);

    finish_run();
  end
endmodule